// File: doc/BRIEF.md
# Configurable GPIO port with change wake-up

This block runs a bidirectional port of up to eight pins under register control. Every pin has a data latch, a direction bit, and three optional modes: pull-high, pull-down and open-drain. The block does not drive pads itself. It presents output-enable, output-value and pull-request vectors that the pad models consume, and it samples the pad levels through a two-flop synchronizer.

The port also watches its input pins for a change in level. Software arms the detector by reading the data register, which records the synchronized pin levels. After that, any input pin whose synchronized level differs from the recorded value sets a sticky interrupt flag. A wake request, which is the flag gated by an enable bit, goes to the power-management logic outside this block.

The register bus is a plain strobe interface with a combinational read path, and it has no back-pressure. A write takes effect at the clock edge where `bus_we` is high. A read of the data register records its snapshot at the clock edge where `bus_re` is high.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, all of the following are zero: the direction, data latch, pull-high, pull-down, open-drain, wake-enable and flag registers. All `pad_oe_o` bits are 0.
- R2: Register address 1 holds the direction bits, where 1 means output. An output pin that is not in open-drain mode has `pad_oe_o`=1 and `pad_out_o` equal to its latch bit. An input pin never has `pad_oe_o`=1.
- R3: Reading address 0 returns, bit by bit, the latch value for output pins and the synchronized pin level for input pins. A pin change shows up after two clock edges. Addresses 1 to 4 read back their register contents, and addresses 6 and 7 read 0.
- R4: Address 4 holds the open-drain bits. An open-drain output pin drives `pad_out_o`=0 with `pad_oe_o`=1 when its latch bit is 0. It releases the line (`pad_oe_o`=0) when its latch bit is 1.
- R5: Address 2 holds the pull-high enables. Each bit appears on `pad_pu_o` whatever the pin's direction.
- R6: Address 3 holds the pull-down enables, and only pins below PD_COUNT (default 4, so pins 0 to 3) can set theirs. The other bits read 0 and never raise `pad_pd_o`.
- R7: Once armed, the flag sets at the clock edge after any input pin's synchronized level differs from the snapshot taken at the last data read. Differences on output pins are ignored.
- R8: The flag (address 5, bit 0) stays set until software writes 1 to address 5 bit 0. A change detected in the same cycle as that write wins, and the flag stays set.
- R9: `irq_o` equals the flag. `wake_o` equals the flag ANDed with the wake-enable bit (address 5, bit 1).
- R10: From reset until the first read of address 0, the detector is disarmed and the flag cannot set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | N_PINS | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of address 0 takes the change snapshot |
| bus_rdata | output | N_PINS | Read data, combinational from bus_addr |
| pin_i | input | N_PINS | Pad input levels (asynchronous) |
| pad_oe_o | output | N_PINS | Per-pin output enable |
| pad_out_o | output | N_PINS | Per-pin output value |
| pad_pu_o | output | N_PINS | Per-pin pull-high request |
| pad_pd_o | output | N_PINS | Per-pin pull-down request |
| irq_o | output | 1 | Input-change interrupt flag |
| wake_o | output | 1 | Wake request (flag and enable) |

## Verification
The port is driven with these patterns:
- A mixed direction split, to show that the data read selects the latch or the pin level per bit.
- Pin toggles before any data read, which tell arming apart from a detector that is always live.
- Toggles confined to output pins, which show the direction mask on the comparison.
- A clear write landing in the same cycle as a fresh change, to expose which of the two takes priority.
- Open-drain set with latch bits both 0 and 1, together with all-ones writes to the pull registers, to separate the drive modes and the pull-down pin limit.

// File: rtl/gwp_pkg.sv
package gwp_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_DIR  = 3'd1;
  localparam logic [2:0] A_PU   = 3'd2;
  localparam logic [2:0] A_PD   = 3'd3;
  localparam logic [2:0] A_OD   = 3'd4;
  localparam logic [2:0] A_CTL  = 3'd5;
  localparam int CTL_FLAG = 0;
  localparam int CTL_WAKE = 1;
endpackage

// File: rtl/gwp_sync.sv
module gwp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      q_o <= '0;
    end else begin
      s1  <= d_i;
      q_o <= s1;
    end
  end
endmodule

// File: rtl/gwp_pad_drive.sv
module gwp_pad_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] od_i,
  input  logic [W-1:0] pu_i,
  input  logic [W-1:0] pd_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o,
  output logic [W-1:0] pd_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe_o[i]  = dir_i[i] & ~(od_i[i] & lat_i[i]);
    assign out_o[i] = lat_i[i] & ~od_i[i];
    assign pu_o[i]  = pu_i[i];
    assign pd_o[i]  = pd_i[i];

    // R4
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (od_i[i] && oe_o[i]) |-> !out_o[i]);
    // R2
    input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_i[i] |-> !oe_o[i]);
  end
endmodule

// File: rtl/gwp_change_det.sv
module gwp_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] dir_i,
  input  logic         snap_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [W-1:0] snap;
  logic         armed;
  logic         chg;

  assign chg = armed && (((level_i ^ snap) & ~dir_i) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      armed  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (snap_i) begin
        snap  <= level_i;
        armed <= 1'b1;
      end
      if (chg)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R10
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !flag_o);
  // R7
  change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> flag_o);
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gwp_pkg::*;
#(
  parameter int N_PINS   = 8,
  parameter int PD_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_pu_o,
  output logic [N_PINS-1:0] pad_pd_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam logic [N_PINS-1:0] PD_MASK = N_PINS'((1 << PD_COUNT) - 1);

  logic [N_PINS-1:0] lat_q, dir_q, pu_q, pd_q, od_q, level;
  logic              wake_en_q, flag;
  logic              snap_req, clr_req;

  gwp_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(level)
  );

  assign snap_req = bus_re && (bus_addr == A_DATA);
  assign clr_req  = bus_we && (bus_addr == A_CTL) && bus_wdata[CTL_FLAG];

  gwp_change_det #(.W(N_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .level_i(level), .dir_i(dir_q),
    .snap_i(snap_req), .clr_i(clr_req), .flag_o(flag)
  );

  gwp_pad_drive #(.W(N_PINS)) u_pad (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_q), .lat_i(lat_q), .od_i(od_q),
    .pu_i(pu_q), .pd_i(pd_q), .oe_o(pad_oe_o), .out_o(pad_out_o),
    .pu_o(pad_pu_o), .pd_o(pad_pd_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q     <= '0;
      dir_q     <= '0;
      pu_q      <= '0;
      pd_q      <= '0;
      od_q      <= '0;
      wake_en_q <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DATA:  lat_q     <= bus_wdata;
        A_DIR:   dir_q     <= bus_wdata;
        A_PU:    pu_q      <= bus_wdata;
        A_PD:    pd_q      <= bus_wdata & PD_MASK;
        A_OD:    od_q      <= bus_wdata;
        A_CTL:   wake_en_q <= bus_wdata[CTL_WAKE];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA: bus_rdata = (dir_q & lat_q) | (~dir_q & level);
      A_DIR:  bus_rdata = dir_q;
      A_PU:   bus_rdata = pu_q;
      A_PD:   bus_rdata = pd_q;
      A_OD:   bus_rdata = od_q;
      A_CTL: begin
        bus_rdata[CTL_FLAG] = flag;
        bus_rdata[CTL_WAKE] = wake_en_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o  = flag;
  assign wake_o = flag & wake_en_q;

  // R6
  pd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pd_o & ~PD_MASK) == '0);
  // R9
  wake_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> irq_o);
endmodule

// File: tb/sim_gpio_wake_port.sv
`timescale 1ns/1ps
module sim_gpio_wake_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_i = '0;
  logic [7:0] pad_oe_o, pad_out_o, pad_pu_o, pad_pd_o;
  logic       irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  gpio_wake_port u0 (.*);

  // behavioural reference state
  logic [7:0] m_lat = '0, m_dir = '0, m_pu = '0, m_pd = '0, m_od = '0;
  logic [7:0] m_snap = '0;
  logic [7:0] m_hist[$];
  logic       m_wake = 1'b0, m_flag = 1'b0, m_armed = 1'b0, m_chg;

  function automatic logic [7:0] m_level();
    return (m_hist.size() >= 2) ? m_hist[1] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = '0; m_dir = '0; m_pu = '0; m_pd = '0; m_od = '0;
      m_snap = '0; m_wake = 0; m_flag = 0; m_armed = 0;
      m_hist.delete();
    end else begin
      m_chg = 1'b0;
      for (int i = 0; i < 8; i++)
        if (m_armed && !m_dir[i] && (m_level()[i] != m_snap[i])) m_chg = 1'b1;
      if (bus_re && bus_addr == 3'd0) begin
        m_snap = m_level();
        m_armed = 1'b1;
      end
      if (m_chg) m_flag = 1'b1;
      else if (bus_we && bus_addr == 3'd5 && bus_wdata[0]) m_flag = 1'b0;
      if (bus_we) begin
        case (bus_addr)
          3'd0: m_lat = bus_wdata;
          3'd1: m_dir = bus_wdata;
          3'd2: m_pu = bus_wdata;
          3'd3: m_pd = bus_wdata & 8'h0F;
          3'd4: m_od = bus_wdata;
          3'd5: m_wake = bus_wdata[1];
          default: ;
        endcase
      end
      m_hist.push_front(pin_i);
      if (m_hist.size() > 2) void'(m_hist.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e_oe, e_out, e_rd;
    cycles++;
    for (int i = 0; i < 8; i++) begin
      if (m_od[i]) begin
        e_out[i] = 1'b0;
        e_oe[i]  = m_dir[i] && !m_lat[i];
      end else begin
        e_out[i] = m_lat[i];
        e_oe[i]  = m_dir[i];
      end
    end
    case (bus_addr)
      3'd0: for (int i = 0; i < 8; i++) e_rd[i] = m_dir[i] ? m_lat[i] : m_level()[i];
      3'd1: e_rd = m_dir;
      3'd2: e_rd = m_pu;
      3'd3: e_rd = m_pd;
      3'd4: e_rd = m_od;
      3'd5: e_rd = {6'b0, m_wake, m_flag};
      default: e_rd = 8'h00;
    endcase
    check("R1 R2 R4 pad_oe", pad_oe_o, e_oe);
    check("R2 R4 pad_out", pad_out_o, e_out);
    check("R5 pad_pu", pad_pu_o, m_pu);
    check("R6 pad_pd", pad_pd_o, m_pd);
    check("R3 rdata", bus_rdata, e_rd);
    check("R7 R8 R10 irq", {7'b0, irq_o}, {7'b0, m_flag});
    check("R9 wake", {7'b0, wake_o}, {7'b0, m_flag & m_wake});
  end

  task automatic cyc(logic we, logic re, logic [2:0] a, logic [7:0] d, logic [7:0] p);
    @(negedge clk); #1;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; pin_i = p;
  endtask

  task automatic idle(int n, logic [2:0] a, logic [7:0] p);
    for (int k = 0; k < n; k++) cyc(0, 0, a, 8'h00, p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values seen through reads
    for (int a = 0; a < 8; a++) idle(1, 3'(a), 8'h00);
    // R10 toggles before arming must not flag
    idle(4, 3'd0, 8'h3C);
    idle(4, 3'd5, 8'hC3);
    // R2 R3 mixed directions
    cyc(1, 0, 3'd0, 8'hA5, 8'h0F);
    cyc(1, 0, 3'd1, 8'hF0, 8'h0F);
    idle(4, 3'd0, 8'h0F);
    cyc(0, 1, 3'd0, 8'h00, 8'h0F);      // arm
    idle(3, 3'd0, 8'h0F);
    // R7 toggle only output pins: no flag
    idle(5, 3'd5, 8'hFF);
    // R7 toggle an input pin
    idle(5, 3'd5, 8'hF7);
    // R8 clear while still different: flag re-sets; then re-snapshot and clear
    cyc(1, 0, 3'd5, 8'h01, 8'hF7);
    cyc(0, 1, 3'd0, 8'h00, 8'hF7);
    cyc(1, 0, 3'd5, 8'h03, 8'hF7);      // clear + wake enable, R9
    idle(3, 3'd5, 8'hF7);
    // R8 clear in same cycle as a new change
    idle(2, 3'd5, 8'hF6);
    cyc(1, 0, 3'd5, 8'h03, 8'hF6);
    idle(3, 3'd5, 8'hF6);
    cyc(1, 0, 3'd5, 8'h03, 8'hF6);
    idle(2, 3'd5, 8'hF6);
    // R4 open drain on output and input pins
    cyc(1, 0, 3'd4, 8'hCC, 8'hF6);
    cyc(1, 0, 3'd0, 8'h4F, 8'hF6);
    idle(2, 3'd4, 8'hF6);
    cyc(1, 0, 3'd0, 8'h80, 8'hF6);
    // R5 R6 pulls
    cyc(1, 0, 3'd2, 8'hFF, 8'hF6);
    cyc(1, 0, 3'd3, 8'hFF, 8'hF6);
    idle(1, 3'd3, 8'hF6);
    cyc(1, 0, 3'd1, 8'h00, 8'hF6);      // all inputs, pulls stay
    idle(2, 3'd2, 8'h5A);
    idle(2, 3'd6, 8'h5A);
    idle(2, 3'd7, 8'h5A);
    cyc(1, 0, 3'd3, 8'h5A, 8'h5A);
    idle(3, 3'd0, 8'h5A);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule